// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers up to 32 peripheral request lines and drives two request outputs toward a processor: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). Each line is conditioned separately. It can be inverted so that it is active-low. It can be level-sensitive, or edge-triggered with the edge held in a pending latch. It is sent to one of the two outputs, and it has an enable bit. Every line also carries an 8-bit priority value. The smallest value wins, and a tie goes to the lower line number.

Software programs the block through a small synchronous register bus. To find out which source to service, it reads a vector register, one for each output. The value returned is the winning line number, or a word with only bit 31 set when nothing is pending on that side. When the acknowledge control bit is set, that read also clears the pending latch of the source it returned. A global mask register gates each output on its own.

Top module: `vpic_top`

## Requirements
- R1: After reset the enable word (address 0) and the global mask (address 4) read 0, both outputs are low, and both vector registers return 32'h8000_0000.
- R2: Bit i of the polarity word (address 1), when set, inverts line i before detection. The active level of a line is its input XOR its polarity bit.
- R3: Bit i of the trigger word (address 2), when set, makes line i level-sensitive: it is pending exactly while it is active. When the bit is clear, a rising edge of the active level, sampled at a clock edge, sets a pending latch, and that latch is visible from the next cycle on.
- R4: Bit i of the route word (address 3), when set, sends line i to the IRQ side. When the bit is clear, it sends line i to the FIQ side.
- R5: Bit i of the enable word (address 0) must be set for line i to become a candidate on either side.
- R6: Bit 0 of the global mask (address 4) allows irq_o and bit 1 allows fiq_o. With either bit clear, its output stays low whatever is pending.
- R7: Priority words live at addresses 16 to 23. Line 4k+j takes its priority from bits 8j+7:8j of word 16+k. Among the candidates, a smaller value wins.
- R8: When the winning priority values are equal, the lower line number wins.
- R9: A read of address 8 (reg_re high for one cycle) returns on reg_rdata in the next cycle. The value is the number of the winning IRQ-side candidate in the low bits, or 32'h8000_0000 if there is none.
- R10: A read of address 9 returns the winning FIQ-side candidate in the same way.
- R11: When bit 31 of the vector control word (address 5) is set, a vector read that returns a valid line clears that line's edge latch. A new edge in the same cycle still sets the latch again. A level-sensitive line stays pending while its input is active.
- R12: irq_o is high exactly when mask bit 0 is set and at least one IRQ-side candidate exists. fiq_o follows the same rule with mask bit 1 and the FIQ side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Peripheral request lines, already synchronous |
| reg_addr | input | 6 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench goes after ties in the priority table. A search written with a less-or-equal compare would return the higher line number. It checks that an edge latch appears one cycle after the edge. A design that makes it visible at once, or never, fails the sampled output in that cycle. It checks acknowledge reads that return an edge source and then a level source. A design that clears nothing would return the edge line twice, and one that treats the level line like a latch would lose it. Random traffic that changes the polarity and route words exposes inversion applied after the edge detector and outputs that are not gated by the global mask.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int REG_AW      = 6;
  localparam int ADR_ENABLE  = 0;
  localparam int ADR_POLAR   = 1;
  localparam int ADR_TRIG    = 2;
  localparam int ADR_ROUTE   = 3;
  localparam int ADR_GMASK   = 4;
  localparam int ADR_VCTRL   = 5;
  localparam int ADR_IRQVEC  = 8;
  localparam int ADR_FIQVEC  = 9;
  localparam int ADR_PRIO    = 16;

  // vector word: line number, or only bit 31 when nothing is pending
  function automatic logic [31:0] vec_word(input logic valid, input logic [31:0] idx);
    return valid ? idx : 32'h8000_0000;
  endfunction

  // line number -> one-hot clear mask
  function automatic logic [31:0] onehot_of(input logic fire, input logic [31:0] idx);
    return fire ? (32'h1 << idx) : 32'h0;
  endfunction
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [31:0]              reg_wdata,
  output logic [NSRC-1:0]          en_q,
  output logic [NSRC-1:0]          pol_q,
  output logic [NSRC-1:0]          lvl_q,
  output logic [NSRC-1:0]          route_q,
  output logic [1:0]               gmask_q,
  output logic                     ack_on_q,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);
  localparam int NPW = (NSRC * PRIO_W + 31) / 32;

  logic [NPW*32-1:0] prio_words;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      pol_q    <= '0;
      lvl_q    <= '0;
      route_q  <= '0;
      gmask_q  <= '0;
      ack_on_q <= 1'b0;
    end else if (reg_we) begin
      case (int'(reg_addr))
        ADR_ENABLE: en_q     <= reg_wdata[NSRC-1:0];
        ADR_POLAR:  pol_q    <= reg_wdata[NSRC-1:0];
        ADR_TRIG:   lvl_q    <= reg_wdata[NSRC-1:0];
        ADR_ROUTE:  route_q  <= reg_wdata[NSRC-1:0];
        ADR_GMASK:  gmask_q  <= reg_wdata[1:0];
        ADR_VCTRL:  ack_on_q <= reg_wdata[31];
        default: ;
      endcase
    end
  end

  for (genvar w = 0; w < NPW; w++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_words[w*32 +: 32] <= '0;
      else if (reg_we && int'(reg_addr) == ADR_PRIO + w)
        prio_words[w*32 +: 32] <= reg_wdata;
    end
  end

  assign prio_flat = prio_words[NSRC*PRIO_W-1:0];
endmodule

// File: rtl/vpic_pend.sv
module vpic_pend #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol_q,
  input  logic [NSRC-1:0] lvl_q,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] edge_now,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_view
);
  logic [NSRC-1:0] act;
  logic [NSRC-1:0] prev_q;

  assign act       = src_i ^ pol_q;
  assign edge_now  = act & ~prev_q;
  assign pend_view = (lvl_q & act) | (~lvl_q & pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= act;
      // a fresh edge wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_mask) | edge_now;
    end
  end
endmodule

// File: rtl/vpic_search.sv
module vpic_search #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower line on a tie
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best      = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic [5:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int NPW   = (NSRC * PRIO_W + 31) / 32;

  logic [NSRC-1:0]        en_q, pol_q, lvl_q, route_q;
  logic [1:0]             gmask_q;
  logic                   ack_on_q;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        edge_now, pend_q, pend_view, clr_mask;
  logic [NSRC-1:0]        irq_cand, fiq_cand;
  logic                   irq_valid, fiq_valid;
  logic [IDX_W-1:0]       irq_idx, fiq_idx;
  logic                   irq_rd, fiq_rd, ack_fire;
  logic [IDX_W-1:0]       ack_idx;
  logic [31:0]            rd_mux;
  logic [NPW*32-1:0]      prio_pad;

  vpic_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .en_q(en_q), .pol_q(pol_q), .lvl_q(lvl_q),
    .route_q(route_q), .gmask_q(gmask_q), .ack_on_q(ack_on_q),
    .prio_flat(prio_flat)
  );

  vpic_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i[NSRC-1:0]), .pol_q(pol_q),
    .lvl_q(lvl_q), .clr_mask(clr_mask), .edge_now(edge_now),
    .pend_q(pend_q), .pend_view(pend_view)
  );

  assign irq_cand = pend_view & en_q & route_q;
  assign fiq_cand = pend_view & en_q & ~route_q;

  vpic_search #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_irq_search (
    .cand(irq_cand), .prio_flat(prio_flat),
    .win_valid(irq_valid), .win_idx(irq_idx)
  );

  vpic_search #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_fiq_search (
    .cand(fiq_cand), .prio_flat(prio_flat),
    .win_valid(fiq_valid), .win_idx(fiq_idx)
  );

  // acknowledge on vector read
  assign irq_rd   = reg_re && int'(reg_addr) == ADR_IRQVEC;
  assign fiq_rd   = reg_re && int'(reg_addr) == ADR_FIQVEC;
  assign ack_fire = ack_on_q && ((irq_rd && irq_valid) || (fiq_rd && fiq_valid));
  assign ack_idx  = irq_rd ? irq_idx : fiq_idx;
  assign clr_mask = NSRC'(onehot_of(ack_fire, 32'(ack_idx)));

  assign prio_pad = (NPW*32)'(prio_flat);

  always_comb begin
    rd_mux = '0;
    case (int'(reg_addr))
      ADR_ENABLE: rd_mux = 32'(en_q);
      ADR_POLAR:  rd_mux = 32'(pol_q);
      ADR_TRIG:   rd_mux = 32'(lvl_q);
      ADR_ROUTE:  rd_mux = 32'(route_q);
      ADR_GMASK:  rd_mux = 32'(gmask_q);
      ADR_VCTRL:  rd_mux = {ack_on_q, 31'b0};
      ADR_IRQVEC: rd_mux = vec_word(irq_valid, 32'(irq_idx));
      ADR_FIQVEC: rd_mux = vec_word(fiq_valid, 32'(fiq_idx));
      default: begin
        for (int w = 0; w < NPW; w++)
          if (int'(reg_addr) == ADR_PRIO + w) rd_mux = prio_pad[w*32 +: 32];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign irq_o = gmask_q[0] & (|irq_cand);
  assign fiq_o = gmask_q[1] & (|fiq_cand);
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int NSRC = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             irq_valid,
  input logic [IDX_W-1:0] irq_idx,
  input logic             fiq_valid,
  input logic [IDX_W-1:0] fiq_idx,
  input logic [NSRC-1:0]  irq_cand,
  input logic [NSRC-1:0]  fiq_cand,
  input logic             ack_fire,
  input logic [IDX_W-1:0] ack_idx,
  input logic [NSRC-1:0]  edge_now,
  input logic [NSRC-1:0]  pend_q
);
  // R12
  irq_needs_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_valid);

  // R12
  fiq_needs_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> fiq_valid);

  // R9
  irq_winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_cand[irq_idx]);

  // R10
  fiq_winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_valid |-> fiq_cand[fiq_idx]);

  // R4
  route_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && fiq_valid) |-> (irq_idx != fiq_idx));

  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !edge_now[ack_idx]) |=> !pend_q[$past(ack_idx)]);

  // R3
  edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_now) |=> ((pend_q & $past(edge_now)) == $past(edge_now)));
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_valid(irq_valid), .irq_idx(irq_idx), .fiq_valid(fiq_valid),
  .fiq_idx(fiq_idx), .irq_cand(irq_cand), .fiq_cand(fiq_cand),
  .ack_fire(ack_fire), .ack_idx(ack_idx), .edge_now(edge_now),
  .pend_q(pend_q)
);

// File: tb/sim_vpic_top.sv
module sim_vpic_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model state
  logic [31:0] m_en = '0, m_pol = '0, m_lvl = '0, m_route = '0;
  logic [1:0]  m_gm = '0;
  logic        m_ack = 1'b0;
  logic [7:0]  m_prio [32];
  logic [31:0] m_pend = '0, m_prev = '0;

  vpic_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] cands(input bit irq_side);
    logic [31:0] act, view;
    act  = src_i ^ m_pol;
    view = (m_lvl & act) | (~m_lvl & m_pend);
    return view & m_en & (irq_side ? m_route : ~m_route);
  endfunction

  // expected vector word: scan from the top so ties fall to the lowest line
  function automatic logic [31:0] exp_vec(input bit irq_side);
    logic [31:0] c, res;
    logic [7:0]  bp;
    c   = cands(irq_side);
    res = 32'h8000_0000;
    bp  = 8'hFF;
    for (int i = 31; i >= 0; i--)
      if (c[i] && m_prio[i] <= bp) begin
        bp  = m_prio[i];
        res = i;
      end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic [31:0] act, edg, clr, v;
      act = src_i ^ m_pol;
      edg = act & ~m_prev;
      clr = '0;
      if (reg_re && m_ack && (reg_addr == 6'd8 || reg_addr == 6'd9)) begin
        v = exp_vec(reg_addr == 6'd8);
        if (!v[31]) clr = 32'h1 << v[4:0];
      end
      m_pend = (m_pend & ~clr) | edg;
      m_prev = act;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      0: m_en = d;
      1: m_pol = d;
      2: m_lvl = d;
      3: m_route = d;
      4: m_gm = d[1:0];
      5: m_ack = d[31];
      default:
        if (a >= 16 && a < 24)
          for (int j = 0; j < 4; j++) m_prio[(a-16)*4+j] = d[j*8 +: 8];
    endcase
  endtask

  task automatic rd(input int a, output logic [31:0] val);
    @(negedge clk);
    reg_addr = 6'(a); reg_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_re = 1'b0;
    val = reg_rdata;
  endtask

  task automatic rd_vec(input string req, input bit irq_side);
    logic [31:0] e, v;
    @(negedge clk);
    e = exp_vec(irq_side);
    rd(irq_side ? 8 : 9, v);
    check(req, v, e);
  endtask

  task automatic chk_outs(input string req);
    #1;
    check({req, " irq_o"}, 32'(irq_o), 32'(m_gm[0] & (|cands(1'b1))));
    check({req, " fiq_o"}, 32'(fiq_o), 32'(m_gm[1] & (|cands(1'b0))));
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m_prio[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    rd(0, v); check("R1 enable", v, 0);
    rd(4, v); check("R1 gmask", v, 0);
    rd(8, v); check("R1 irq vec", v, 32'h8000_0000);
    rd(9, v); check("R1 fiq vec", v, 32'h8000_0000);

    // level lines 5 and 9, IRQ side, equal priority
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(4, 32'd3);
    @(negedge clk); src_i = (32'h1 << 5) | (32'h1 << 9);
    rd(8, v); check("R8 tie lower index", v, 32'd5);
    // R7: line 5 lives in word 17, byte 1
    wr(17, 32'h0000_0200);
    rd(8, v); check("R7 smaller value wins", v, 32'd9);
    // R2: invert line 9
    wr(1, 32'h1 << 9);
    rd(8, v); check("R2 polarity", v, 32'd5);
    // R6
    wr(4, 32'd2);
    #1; check("R6 irq masked", 32'(irq_o), 0);
    wr(4, 32'd3);
    #1; check("R12 irq up", 32'(irq_o), 1);
    // R5
    wr(0, ~(32'h1 << 5));
    rd(8, v); check("R5 enable gates", v, 32'h8000_0000);

    // edge line 3 with acknowledge
    wr(1, 32'h0);
    wr(2, 32'h0);
    wr(0, 32'h1 << 3);
    wr(5, 32'h8000_0000);
    @(negedge clk); src_i = 32'h0;
    @(negedge clk); src_i = 32'h1 << 3;
    #1; check("R3 edge not yet visible", 32'(irq_o), 0);
    @(negedge clk);
    #1; check("R3 edge latched", 32'(irq_o), 1);
    rd(8, v); check("R9 irq vec edge", v, 32'd3);
    rd(8, v); check("R11 ack cleared edge", v, 32'h8000_0000);
    wr(2, 32'h1 << 3);
    rd(8, v); check("R11 level kept 1", v, 32'd3);
    rd(8, v); check("R11 level kept 2", v, 32'd3);
    // R4 / R10: route line 3 to FIQ
    wr(3, ~(32'h1 << 3));
    #1; check("R4 irq off", 32'(irq_o), 0);
    check("R4 fiq on", 32'(fiq_o), 1);
    rd(9, v); check("R10 fiq vec", v, 32'd3);

    // constrained random traffic
    for (int it = 0; it < 600; it++) begin
      int sel;
      @(negedge clk);
      if ($urandom % 3 != 0) src_i = $urandom & $urandom;
      chk_outs("R12 random");
      sel = $urandom % 10;
      case (sel)
        0: wr($urandom % 4, $urandom);
        1: wr(4, ($urandom % 4 == 0) ? 32'(($urandom % 4)) : 32'd3);
        2: wr(5, {$urandom % 2 == 1, 31'b0});
        3: wr(16 + $urandom % 8, $urandom & 32'h0303_0303);
        4, 5: rd_vec("R9 random irq vec", 1'b1);
        6, 7: rd_vec("R10 random fiq vec", 1'b0);
        default: ;
      endcase
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule